// File: doc/BRIEF.md
# Gain-Scaled Eight-to-Two Lane Serializer

This block sits between a bank of eight parallel waveform generators and a dual-port DAC. The generators produce eight 11-bit signed samples together in each slow-rate period. Each sample is multiplied by a common programmable gain, then rounded and clamped back to 11 bits. The scaled group is then spread over two DAC ports across four link-clock slots. The DAC takes one word from each port per link clock and interleaves them, so the sample order is restored at the converter.

The whole block runs on the link clock. The slow lane rate is an internal one-in-four capture slot that is aligned to reset release. A behavioural shift structure does the 4:1 multiplexing that dedicated I/O serializer hardware would do in a device. A word strobe marks the first slot of every valid group, so a downstream checker can frame the words.

Top module: `dac_lane_serializer`

## Requirements
- R1: While reset is asserted, and after it until the first valid group arrives, both data ports read zero and the word strobe is low.
- R2: The inputs (samples, gain, valid) are sampled on the 4th rising link-clock edge after reset release and on every 4th edge after that. Input values present at any other edge have no effect on the outputs.
- R3: Each lane output equals floor((s*g + 2^16) / 2^17). Here s is the lane's 11-bit two's-complement sample, and g is the unsigned 18-bit gain in which 131072 means unity (round half toward plus infinity).
- R4: A scaled value above 1023 is output as 1023. A scaled value below -1024 is output as -1024.
- R5: A group sampled on edge E puts its first words on the ports, and raises the strobe, in the link cycle that follows edge E+4.
- R6: Over its four slots, port A carries lanes 0, 2, 4, 6 and port B carries lanes 1, 3, 5, 7, one pair per link cycle in ascending order.
- R7: The word strobe is high for exactly the first slot of each valid group and is low in every other cycle.
- R8: For a group sampled with valid low, both ports read zero for its four slots.
- R9: Valid groups sampled on consecutive capture edges stream out with no idle slot between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, four times the lane rate |
| rst | input | 1 | Synchronous active-high reset |
| samplesIn | input | 88 | Eight signed 11-bit samples, lane n in bits [11n+10:11n] |
| validIn | input | 1 | Marks the sample group as valid |
| gainIn | input | 18 | Unsigned gain, Q1.17 |
| dacPortA | output | 11 | Even-lane words toward the DAC |
| dacPortB | output | 11 | Odd-lane words toward the DAC |
| wordStrobe | output | 1 | High in the first slot of each valid group |

## Verification
The assertions assume that samples, gain and valid only matter at the capture edge. They also assume that the strobe pattern depends only on the capture slot counter started by reset. The stimulus follows this: each group is held as one four-cycle window that begins at reset release, so the capture edge always sees a settled group. Some windows deliberately fill their three non-capture cycles with random garbage, including random valid and gain, so the one-in-four sampling is exercised at the ports. Gains cover zero, half, unity and full scale, with samples at the signed extremes, so that rounding ties and both clamps are reached.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  localparam int SAMPLE_W = 11;
  localparam int GAIN_W   = 18;
  localparam int LANES    = 8;
  localparam int PORTS    = 2;
  localparam int SLOTS    = LANES / PORTS;
  localparam int SLOT_W   = $clog2(SLOTS);

  typedef struct packed {
    logic capture;     // lane-rate edge: sample inputs, load the port shifters
    logic groupValid;  // valid flag of the group held in the product registers
  } ctrl_t;
endpackage

// File: rtl/dac_ser_lane_gain.sv
module dac_ser_lane_gain
  import dac_ser_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int GW = GAIN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [SW-1:0] sample,
  input  logic [GW-1:0] gain,
  output logic [SW-1:0] scaled
);
  localparam int PW   = SW + GW + 1;
  localparam int FRAC = GW - 1;
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (SW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic [GW-1:0] UNITY = GW'(1) << FRAC;

  logic signed [PW-1:0] fullProd, roundedProd, shiftedProd;
  logic [SW-1:0] clamped;

  always_comb begin
    fullProd    = PW'($signed(sample)) * $signed({1'b0, gain});
    roundedProd = fullProd + HALF;
    shiftedProd = roundedProd >>> FRAC;
    if (shiftedProd > MAXV)      clamped = MAXV[SW-1:0];
    else if (shiftedProd < MINV) clamped = MINV[SW-1:0];
    else                         clamped = shiftedProd[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          scaled <= '0;
    else if (capture) scaled <= clamped;
  end

  assert_unity_gain_R3: assert property (@(posedge clk) disable iff (rst)
    (capture && gain == UNITY) |=> scaled == $past(sample));

  assert_sign_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (capture && !sample[SW-1]) |=> !scaled[SW-1]);

  assert_clamp_low_R4: assert property (@(posedge clk) disable iff (rst)
    (capture && sample == {1'b1, {(SW-1){1'b0}}} && gain > UNITY)
      |=> scaled == {1'b1, {(SW-1){1'b0}}});
endmodule

// File: rtl/dac_ser_port_mux.sv
module dac_ser_port_mux
  import dac_ser_pkg::*;
#(
  parameter int SW    = SAMPLE_W,
  parameter int NSLOT = SLOTS
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrl_t               ctrl,
  input  logic [NSLOT*SW-1:0] words,   // slot k in bits [k*SW +: SW]
  output logic [SW-1:0]       portOut
);
  logic [SW-1:0] stage [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NSLOT; k++) stage[k] <= '0;
    end else if (ctrl.capture) begin
      for (int k = 0; k < NSLOT; k++)
        stage[k] <= ctrl.groupValid ? words[k*SW +: SW] : '0;
    end else begin
      for (int k = 0; k < NSLOT - 1; k++) stage[k] <= stage[k+1];
      stage[NSLOT-1] <= '0;
    end
  end

  assign portOut = stage[0];

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && !ctrl.groupValid) |=> portOut == '0);
endmodule

// File: rtl/dac_ser_datapath.sv
module dac_ser_datapath
  import dac_ser_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  ctrl_t                   ctrl,
  input  logic [LANES*SAMPLE_W-1:0] samplesIn,
  input  logic [GAIN_W-1:0]       gainIn,
  output logic [PORTS*SAMPLE_W-1:0] portsOut
);
  logic [LANES*SAMPLE_W-1:0] scaledLanes;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dac_ser_lane_gain #(.SW(SAMPLE_W), .GW(GAIN_W)) u_gain (
      .clk(clk), .rst(rst), .capture(ctrl.capture),
      .sample(samplesIn[l*SAMPLE_W +: SAMPLE_W]), .gain(gainIn),
      .scaled(scaledLanes[l*SAMPLE_W +: SAMPLE_W]));
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [SLOTS*SAMPLE_W-1:0] portWords;
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign portWords[k*SAMPLE_W +: SAMPLE_W] =
        scaledLanes[(k*PORTS + p)*SAMPLE_W +: SAMPLE_W];
    end
    dac_ser_port_mux #(.SW(SAMPLE_W), .NSLOT(SLOTS)) u_mux (
      .clk(clk), .rst(rst), .ctrl(ctrl), .words(portWords),
      .portOut(portsOut[p*SAMPLE_W +: SAMPLE_W]));
  end
endmodule

// File: rtl/dac_ser_ctrl.sv
module dac_ser_ctrl
  import dac_ser_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  validIn,
  output ctrl_t ctrl,
  output logic  wordStrobe
);
  logic [SLOT_W-1:0] slotCnt;
  logic              heldValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt    <= '0;
      heldValid  <= 1'b0;
      wordStrobe <= 1'b0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
      if (ctrl.capture) begin
        heldValid  <= validIn;
        wordStrobe <= heldValid;
      end else begin
        wordStrobe <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl.capture    = (slotCnt == SLOT_W'(SLOTS - 1));
    ctrl.groupValid = heldValid;
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    wordStrobe |=> !wordStrobe);

  assert_strobe_after_load_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wordStrobe) |-> $past(ctrl.capture));
endmodule

// File: rtl/dac_lane_serializer.sv
module dac_lane_serializer
  import dac_ser_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*SAMPLE_W-1:0] samplesIn,
  input  logic                      validIn,
  input  logic [GAIN_W-1:0]         gainIn,
  output logic [SAMPLE_W-1:0]       dacPortA,
  output logic [SAMPLE_W-1:0]       dacPortB,
  output logic                      wordStrobe
);
  ctrl_t ctrl;
  logic [PORTS*SAMPLE_W-1:0] portsOut;

  dac_ser_ctrl u_ctrl (
    .clk(clk), .rst(rst), .validIn(validIn), .ctrl(ctrl), .wordStrobe(wordStrobe));

  dac_ser_datapath u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .samplesIn(samplesIn), .gainIn(gainIn),
    .portsOut(portsOut));

  assign dacPortA = portsOut[0 +: SAMPLE_W];
  assign dacPortB = portsOut[SAMPLE_W +: SAMPLE_W];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wordStrobe && dacPortA == '0 && dacPortB == '0));
endmodule

// File: tb/sim_dac_lane_serializer.sv
`timescale 1ns/1ps
module sim_dac_lane_serializer;
  localparam int SW = 11, GW = 18, NL = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NL*SW-1:0] samplesIn = '0;
  logic             validIn = 1'b0;
  logic [GW-1:0]    gainIn = '0;
  logic [SW-1:0]    dacPortA, dacPortB;
  logic             wordStrobe;

  dac_lane_serializer u0 (.clk(clk), .rst(rst), .samplesIn(samplesIn), .validIn(validIn),
    .gainIn(gainIn), .dacPortA(dacPortA), .dacPortB(dacPortB), .wordStrobe(wordStrobe));

  typedef struct { int due; int w[8]; } exp_t;
  exp_t q[$];
  exp_t cur;
  int checks = 0, errors = 0, edgeCnt = 0, groupIdx = 0, pend = 0, slotIdx = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int scaleOne(input int s, input int g);
    longint p = longint'(s) * longint'(g);
    longint r = (p + 64'sd65536) >>> 17;   // R3 rounding
    if (r > 1023) r = 1023;                // R4 clamps
    if (r < -1024) r = -1024;
    return int'(r);
  endfunction

  task automatic sendGroup(input int s[8], input int g, input bit v, input bit garble);
    exp_t e;
    for (int i = 0; i < 4; i++) begin
      if (garble && i < 3) begin
        samplesIn = {$urandom(), $urandom(), $urandom()};
        validIn   = 1'($urandom());
        gainIn    = GW'($urandom());
      end else begin
        for (int l = 0; l < NL; l++) samplesIn[l*SW +: SW] = s[l][SW-1:0];
        gainIn  = g[GW-1:0];
        validIn = v;
      end
      @(negedge clk);
    end
    if (v) begin
      e.due = 4 * groupIdx + 8;              // R5: capture edge 4*(k+1), out 4 edges later
      for (int l = 0; l < NL; l++) e.w[l] = scaleOne(s[l], g);
      q.push_back(e);
    end
    groupIdx++;
  endtask

  always @(posedge clk) edgeCnt <= rst ? 0 : edgeCnt + 1;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (pend == 0) begin
        if (wordStrobe) begin
          if (q.size() == 0) chk(0, "R7 unexpected strobe", 1, 0);
          else begin
            cur = q.pop_front();
            chk(edgeCnt == cur.due, "R5/R9 strobe timing", edgeCnt, cur.due);
            chk(int'($signed(dacPortA)) == cur.w[0], "R6 port A slot 0", int'($signed(dacPortA)), cur.w[0]);
            chk(int'($signed(dacPortB)) == cur.w[1], "R6 port B slot 0", int'($signed(dacPortB)), cur.w[1]);
            pend = 3; slotIdx = 1;
          end
        end else begin
          chk(dacPortA == '0 && dacPortB == '0, "R8 idle slots zero",
              int'(dacPortA) | int'(dacPortB), 0);
        end
      end else begin
        chk(!wordStrobe, "R7 strobe only in first slot", int'(wordStrobe), 0);
        chk(int'($signed(dacPortA)) == cur.w[2*slotIdx], "R6 port A order",
            int'($signed(dacPortA)), cur.w[2*slotIdx]);
        chk(int'($signed(dacPortB)) == cur.w[2*slotIdx+1], "R6 port B order",
            int'($signed(dacPortB)), cur.w[2*slotIdx+1]);
        slotIdx++; pend--;
      end
    end
  end

  initial begin
    int s[8];
    repeat (3) @(negedge clk);
    chk(dacPortA == '0 && dacPortB == '0 && !wordStrobe, "R1 reset state",
        int'(dacPortA) | int'(dacPortB) | int'(wordStrobe), 0);
    rst = 1'b0;
    // R3 unity gain ramp
    s = '{0, 1, -1, 100, -100, 1023, -1024, 512};
    sendGroup(s, 131072, 1, 0);
    // R3 half gain with rounding ties
    s = '{1, -1, 3, -3, 1023, -1024, 2, -2};
    sendGroup(s, 65536, 1, 0);
    // R4 full-scale gain clamps both ways
    s = '{1023, -1024, 700, -700, 511, -513, 0, 1};
    sendGroup(s, 262143, 1, 0);
    // R2 garbage between capture edges is ignored
    s = '{10, 20, 30, 40, -50, -60, -70, -80};
    sendGroup(s, 98304, 1, 1);
    // R8 invalid group with garbage around it
    sendGroup(s, 131072, 0, 1);
    // R3 zero gain
    s = '{1023, -1024, 5, -5, 300, -300, 7, -7};
    sendGroup(s, 0, 1, 0);
    // R9 back-to-back random groups
    for (int k = 0; k < 24; k++) begin
      for (int l = 0; l < NL; l++) s[l] = int'($urandom_range(2047)) - 1024;
      sendGroup(s, int'($urandom_range(262143)), 1, (k % 5) == 2);
    end
    for (int k = 0; k < 4; k++) sendGroup(s, 0, 0, 0);
    while (q.size() != 0 || pend != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule